// File: doc/BRIEF.md
# UART Byte FIFO Router with Channel Modes

This block sits between the bit-level serial engine of a UART and its bus register file. It owns two byte FIFOs: one that feeds the bus data register on reads (the receive FIFO) and one that feeds the serial transmitter (the transmit FIFO). A 2-bit channel mode decides where each byte goes. Bytes from the serial receiver and bytes written to the data register are steered into the receive FIFO, the transmit FIFO, both, or neither. Loopback and echo configurations therefore need no extra datapath.

A 9-bit control register, written and read over the bus, enables or disables each direction. It also holds two self-clearing flush commands and the break start/stop pair. A detected line break is turned into a zero byte in the receive FIFO. A single overrun pulse reports any byte that had to be thrown away because its FIFO was full. The serial receiver sees a ready signal that is low whenever a FIFO its byte would enter has no room. The transmitter drains the transmit FIFO through a valid/ready handshake.

Top module: `uart_chan_router`

## Requirements
- R1: After reset the control register reads 0x128 (receive and transmit disabled, stop-break set), both FIFO counts are 0, `tx_valid` is 0, `brk_out` is 0 and `ser_rx_ready` is 1.
- R2: A control write with bit 0 set empties the receive FIFO, and one with bit 1 set empties the transmit FIFO, both by the next cycle. Both bits always read back as 0, and the other written bits are kept.
- R3: The receive path is active only when control bit 2 is 1 and bit 3 is 0. The transmit path is active only when bit 4 is 1 and bit 5 is 0. An inactive path takes no pushes and no pops: its count is unchanged, a data read returns 0, and no overrun is raised.
- R4: Mode 0 (normal): serial bytes enter the receive FIFO and data-register writes enter the transmit FIFO.
- R5: Mode 1 (echo): serial bytes enter both FIFOs, and data-register writes are dropped.
- R6: Mode 2 (local loopback): data-register writes enter the receive FIFO, and serial bytes are dropped.
- R7: Mode 3 (remote loopback): serial bytes enter the transmit FIFO, and data-register writes are dropped.
- R8: A byte pushed into a full active FIFO is discarded and the FIFO is unchanged. `ovr_pulse` is 1 for exactly the cycle after the push, and this holds for both FIFOs.
- R9: `data_rdata` shows the oldest receive byte, and the FIFO is first-in first-out. A data read pops one byte. A read of an empty FIFO returns 0 and changes nothing.
- R10: A `brk_det` pulse pushes 0x00 into the receive FIFO in any mode. It takes priority over a serial byte in the same cycle, and that serial byte is lost.
- R11: `ser_rx_ready` is 1 exactly when no FIFO that the current mode routes serial bytes into is full.
- R12: `brk_out` is 1 exactly when control bit 7 is 1 and bit 8 is 0.
- R13: `tx_valid` is 1 when the transmit path is active and its FIFO is non-empty. `tx_data` is the oldest byte, and a byte is popped on each cycle with `tx_valid` and `tx_ready` both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Channel mode: 0 normal, 1 echo, 2 local loopback, 3 remote loopback |
| ser_rx_data | input | 8 | Byte from the serial receiver |
| ser_rx_valid | input | 1 | Serial byte strobe |
| ser_rx_ready | output | 1 | Room in every FIFO the mode routes serial bytes to |
| brk_det | input | 1 | Line break detected pulse |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 9 | Control write value |
| ctrl_rdata | output | 9 | Control register read value |
| data_wr | input | 1 | Data register write strobe |
| data_wdata | input | 8 | Data register write byte |
| data_rd | input | 1 | Data register read strobe (pops receive FIFO) |
| data_rdata | output | 8 | Data register read byte |
| tx_data | output | 8 | Byte to the transmitter |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Transmitter takes the byte |
| rx_count | output | CW | Receive FIFO fill level |
| tx_count | output | CW | Transmit FIFO fill level |
| ovr_pulse | output | 1 | One-cycle overrun indication |
| brk_out | output | 1 | Break transmission request |

## Verification
The bench drives each of the eight pairs of mode and source through the routing. A swapped mode decode would show up as a count moving in the wrong FIFO. It fills a FIFO to its depth and pushes once more. A design that wrapped its write pointer would overwrite the oldest byte and change the head, and a missing overrun pulse, or one that stays high, is caught cycle by cycle. It reads while the path is disabled and while the FIFO is empty, where a careless pop would lose a byte or return stale data. It also sends a break together with a serial byte, to expose a design that lets the serial byte win.

// File: rtl/uart_chan_pkg.sv
package uart_chan_pkg;

    typedef enum logic [1:0] {
        CH_NORMAL = 2'd0,
        CH_ECHO   = 2'd1,
        CH_LOCAL  = 2'd2,
        CH_REMOTE = 2'd3
    } chan_mode_e;

    localparam int CTL_W       = 9;
    localparam int CTL_RX_FLSH = 0;
    localparam int CTL_TX_FLSH = 1;
    localparam int CTL_RX_EN   = 2;
    localparam int CTL_RX_DIS  = 3;
    localparam int CTL_TX_EN   = 4;
    localparam int CTL_TX_DIS  = 5;
    localparam int CTL_BRK_GO  = 7;
    localparam int CTL_BRK_END = 8;
    localparam logic [CTL_W-1:0] CTL_RESET = 9'h128;

endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [CW-1:0] count,
    output logic [DW-1:0] head,
    output logic          full,
    output logic          empty,
    output logic          drop
);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic wr_ok, rd_ok;

    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign wr_ok = push && !full && !flush;
    assign rd_ok = pop && !empty && !flush;
    assign drop  = push && full && !flush;
    assign count = st_q.cnt;
    assign head  = mem_q[st_q.rptr];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.wptr = '0;
            st_d.rptr = '0;
            st_d.cnt  = '0;
        end else begin
            if (wr_ok) st_d.wptr = nxt(st_q.wptr);
            if (rd_ok) st_d.rptr = nxt(st_q.rptr);
            if (wr_ok && !rd_ok)      st_d.cnt = st_q.cnt + CW'(1);
            else if (rd_ok && !wr_ok) st_d.cnt = st_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem_q[st_q.wptr] <= push_data;
    end

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));

    // R8
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (count == CW'(DEPTH)));

    // R2
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/uart_chan_ctrl.sv
module uart_chan_ctrl
    import uart_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    output logic [CTL_W-1:0] rdata,
    output logic             rx_flush,
    output logic             tx_flush,
    output logic             rx_active,
    output logic             tx_active,
    output logic             brk_out
);

    typedef struct packed {
        logic [CTL_W-1:0] ctl;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.ctl = wdata;
            st_d.ctl[CTL_RX_FLSH] = 1'b0;
            st_d.ctl[CTL_TX_FLSH] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.ctl <= CTL_RESET;
        else        st_q <= st_d;
    end

    assign rdata     = st_q.ctl;
    assign rx_flush  = wr && wdata[CTL_RX_FLSH];
    assign tx_flush  = wr && wdata[CTL_TX_FLSH];
    assign rx_active = st_q.ctl[CTL_RX_EN] && !st_q.ctl[CTL_RX_DIS];
    assign tx_active = st_q.ctl[CTL_TX_EN] && !st_q.ctl[CTL_TX_DIS];
    assign brk_out   = st_q.ctl[CTL_BRK_GO] && !st_q.ctl[CTL_BRK_END];

    // R2
    selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (wdata[CTL_RX_FLSH] || wdata[CTL_TX_FLSH])) |=> (rdata[1:0] == 2'b00));

endmodule

// File: rtl/uart_chan_router.sv
module uart_chan_router
    import uart_chan_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [7:0]       ser_rx_data,
    input  logic             ser_rx_valid,
    output logic             ser_rx_ready,
    input  logic             brk_det,
    input  logic             ctrl_wr,
    input  logic [CTL_W-1:0] ctrl_wdata,
    output logic [CTL_W-1:0] ctrl_rdata,
    input  logic             data_wr,
    input  logic [7:0]       data_wdata,
    input  logic             data_rd,
    output logic [7:0]       data_rdata,
    output logic [7:0]       tx_data,
    output logic             tx_valid,
    input  logic             tx_ready,
    output logic [CW-1:0]    rx_count,
    output logic [CW-1:0]    tx_count,
    output logic             ovr_pulse,
    output logic             brk_out
);

    typedef struct packed {
        logic ovr;
    } top_st_t;

    top_st_t st_d, st_q;

    chan_mode_e cm;
    logic rx_flush, tx_flush, rx_active, tx_active;
    logic ser_to_rx, ser_to_tx, bus_to_rx, bus_to_tx;
    logic rx_push, tx_push, rx_pop, tx_pop;
    logic [7:0] rx_pdata, tx_pdata, rx_head, tx_head;
    logic rx_full, rx_empty, tx_full, tx_empty, rx_drop, tx_drop;

    uart_chan_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (ctrl_wr),
        .wdata     (ctrl_wdata),
        .rdata     (ctrl_rdata),
        .rx_flush  (rx_flush),
        .tx_flush  (tx_flush),
        .rx_active (rx_active),
        .tx_active (tx_active),
        .brk_out   (brk_out)
    );

    assign cm        = chan_mode_e'(mode);
    assign ser_to_rx = (cm == CH_NORMAL) || (cm == CH_ECHO);
    assign ser_to_tx = (cm == CH_ECHO)   || (cm == CH_REMOTE);
    assign bus_to_rx = (cm == CH_LOCAL);
    assign bus_to_tx = (cm == CH_NORMAL);

    always_comb begin
        rx_push  = rx_active && (brk_det || (ser_rx_valid && ser_to_rx) || (data_wr && bus_to_rx));
        if (brk_det)                     rx_pdata = 8'h00;
        else if (bus_to_rx && data_wr)   rx_pdata = data_wdata;
        else                             rx_pdata = ser_rx_data;
        tx_push  = tx_active && ((ser_rx_valid && ser_to_tx) || (data_wr && bus_to_tx));
        tx_pdata = bus_to_tx ? data_wdata : ser_rx_data;
        rx_pop   = data_rd && rx_active;
        tx_pop   = tx_valid && tx_ready;
    end

    uart_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (rx_flush),
        .push      (rx_push),
        .push_data (rx_pdata),
        .pop       (rx_pop),
        .count     (rx_count),
        .head      (rx_head),
        .full      (rx_full),
        .empty     (rx_empty),
        .drop      (rx_drop)
    );

    uart_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (tx_flush),
        .push      (tx_push),
        .push_data (tx_pdata),
        .pop       (tx_pop),
        .count     (tx_count),
        .head      (tx_head),
        .full      (tx_full),
        .empty     (tx_empty),
        .drop      (tx_drop)
    );

    always_comb begin
        st_d.ovr = rx_drop || tx_drop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ovr_pulse    = st_q.ovr;
    assign data_rdata   = (rx_active && !rx_empty) ? rx_head : 8'h00;
    assign tx_valid     = tx_active && !tx_empty;
    assign tx_data      = tx_head;
    assign ser_rx_ready = !(ser_to_rx && rx_full) && !(ser_to_tx && tx_full);

    // R11
    ready_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cm == CH_NORMAL) && !ser_rx_ready) |-> (rx_count == CW'(DEPTH)));

    // R9
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |-> (data_rdata == 8'h00));

    // R13
    tx_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_count != '0));

    // R2
    rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_wdata[CTL_RX_FLSH]) |=> (rx_count == '0));

    // R3
    rx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_active && !ctrl_wr) |=> $stable(rx_count));

endmodule

// File: tb/uart_chan_router_bench.sv
module uart_chan_router_bench;

    localparam int DEPTH = 4;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [7:0] ser_rx_data = 8'h00;
    logic ser_rx_valid = 1'b0;
    logic ser_rx_ready;
    logic brk_det = 1'b0;
    logic ctrl_wr = 1'b0;
    logic [8:0] ctrl_wdata = 9'h000;
    logic [8:0] ctrl_rdata;
    logic data_wr = 1'b0;
    logic [7:0] data_wdata = 8'h00;
    logic data_rd = 1'b0;
    logic [7:0] data_rdata;
    logic [7:0] tx_data;
    logic tx_valid;
    logic tx_ready = 1'b0;
    logic [CW-1:0] rx_count, tx_count;
    logic ovr_pulse, brk_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    uart_chan_router #(.DEPTH(DEPTH)) u_uart_chan_router (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .ser_rx_data(ser_rx_data), .ser_rx_valid(ser_rx_valid), .ser_rx_ready(ser_rx_ready),
        .brk_det(brk_det), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
        .data_wr(data_wr), .data_wdata(data_wdata), .data_rd(data_rd), .data_rdata(data_rdata),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_count(rx_count), .tx_count(tx_count), .ovr_pulse(ovr_pulse), .brk_out(brk_out)
    );

    // mode[4:3], source[2] (0 serial, 1 bus), rx gains[1], tx gains[0]
    localparam logic [4:0] ROUTE_VEC [8] = '{
        5'b00_0_1_0, 5'b00_1_0_1,
        5'b01_0_1_1, 5'b01_1_0_0,
        5'b10_0_0_0, 5'b10_1_1_0,
        5'b11_0_0_1, 5'b11_1_0_0
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_ctrl(input logic [8:0] v);
        ctrl_wr = 1'b1; ctrl_wdata = v;
        tick();
        ctrl_wr = 1'b0;
    endtask

    task automatic bus_push(input logic [7:0] b);
        data_wr = 1'b1; data_wdata = b;
        tick();
        data_wr = 1'b0;
    endtask

    task automatic ser_push(input logic [7:0] b);
        ser_rx_valid = 1'b1; ser_rx_data = b;
        tick();
        ser_rx_valid = 1'b0;
    endtask

    task automatic bus_pop();
        data_rd = 1'b1;
        tick();
        data_rd = 1'b0;
    endtask

    initial begin
        while (cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        chk("watchdog", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #13 rst_n = 1'b1;
        tick();
        // R1
        chk("R1 ctrl", int'(ctrl_rdata), 'h128);
        chk("R1 rx_count", int'(rx_count), 0);
        chk("R1 tx_count", int'(tx_count), 0);
        chk("R1 tx_valid", int'(tx_valid), 0);
        chk("R1 brk_out", int'(brk_out), 0);
        chk("R1 ready", int'(ser_rx_ready), 1);

        wr_ctrl(9'h114);

        // R4 R5 R6 R7 routing table
        for (int i = 0; i < 8; i++) begin
            logic [4:0] v;
            logic [7:0] b;
            v = ROUTE_VEC[i];
            b = 8'h40 + 8'(i);
            wr_ctrl(9'h117);
            mode = v[4:3];
            if (v[2]) bus_push(b);
            else      ser_push(b);
            chk($sformatf("R4-7 vec%0d rx_count (R%0d)", i, 4 + int'(v[4:3])), int'(rx_count), int'(v[1]));
            chk($sformatf("R4-7 vec%0d tx_count (R%0d)", i, 4 + int'(v[4:3])), int'(tx_count), int'(v[0]));
            if (v[1]) chk("R9 routed head", int'(data_rdata), int'(b));
            if (v[0]) chk("R13 routed tx_data", int'(tx_data), int'(b));
        end

        // R9 order and empty read
        wr_ctrl(9'h117);
        mode = 2'd2;
        bus_push(8'h11);
        bus_push(8'h22);
        chk("R9 first", int'(data_rdata), 'h11);
        bus_pop();
        chk("R9 second", int'(data_rdata), 'h22);
        bus_pop();
        chk("R9 empty data", int'(data_rdata), 0);
        bus_pop();
        chk("R9 empty count", int'(rx_count), 0);

        // R8 overrun on receive FIFO
        for (int k = 0; k < DEPTH; k++) bus_push(8'h60 + 8'(k));
        chk("R8 no ovr at fill", int'(ovr_pulse), 0);
        bus_push(8'h99);
        chk("R8 ovr pulse", int'(ovr_pulse), 1);
        chk("R8 count held", int'(rx_count), DEPTH);
        chk("R8 head kept", int'(data_rdata), 'h60);
        tick();
        chk("R8 ovr one cycle", int'(ovr_pulse), 0);

        // R11 readiness by mode, receive FIFO full
        mode = 2'd0; #1;
        chk("R11 normal full", int'(ser_rx_ready), 0);
        mode = 2'd3; #1;
        chk("R11 remote", int'(ser_rx_ready), 1);
        mode = 2'd1; #1;
        chk("R11 echo", int'(ser_rx_ready), 0);

        // R8 overrun on transmit FIFO
        mode = 2'd0;
        for (int k = 0; k < DEPTH; k++) bus_push(8'h70 + 8'(k));
        bus_push(8'h98);
        chk("R8 tx ovr", int'(ovr_pulse), 1);
        chk("R8 tx count", int'(tx_count), DEPTH);

        // R2 flush keeps other bits
        wr_ctrl(9'h115);
        chk("R2 rx flushed", int'(rx_count), 0);
        chk("R2 tx kept", int'(tx_count), DEPTH);
        chk("R2 readback", int'(ctrl_rdata), 'h114);
        wr_ctrl(9'h116);
        chk("R2 tx flushed", int'(tx_count), 0);

        // R3 disabled receive path
        ser_push(8'h5C);
        wr_ctrl(9'h11C);
        chk("R3 disabled read", int'(data_rdata), 0);
        bus_pop();
        chk("R3 pop ignored", int'(rx_count), 1);
        ser_push(8'h5D);
        chk("R3 push ignored", int'(rx_count), 1);
        chk("R3 no ovr", int'(ovr_pulse), 0);
        wr_ctrl(9'h114);
        chk("R3 byte intact", int'(data_rdata), 'h5C);

        // R10 break insertion with priority
        wr_ctrl(9'h117);
        mode = 2'd2;
        brk_det = 1'b1; tick(); brk_det = 1'b0;
        chk("R10 break count", int'(rx_count), 1);
        chk("R10 break byte", int'(data_rdata), 0);
        wr_ctrl(9'h117);
        mode = 2'd0;
        brk_det = 1'b1; ser_rx_valid = 1'b1; ser_rx_data = 8'hEE;
        tick();
        brk_det = 1'b0; ser_rx_valid = 1'b0;
        chk("R10 priority count", int'(rx_count), 1);
        chk("R10 priority byte", int'(data_rdata), 0);

        // R12 break output
        wr_ctrl(9'h194);
        chk("R12 stop wins", int'(brk_out), 0);
        wr_ctrl(9'h094);
        chk("R12 start", int'(brk_out), 1);

        // R13 transmit handshake
        wr_ctrl(9'h117);
        bus_push(8'hA5);
        bus_push(8'h5A);
        chk("R13 valid", int'(tx_valid), 1);
        chk("R13 head", int'(tx_data), 'hA5);
        tx_ready = 1'b1; tick(); tx_ready = 1'b0;
        chk("R13 next", int'(tx_data), 'h5A);
        chk("R13 count", int'(tx_count), 1);
        wr_ctrl(9'h134);
        chk("R13 R3 valid off", int'(tx_valid), 0);
        tx_ready = 1'b1; tick(); tx_ready = 1'b0;
        chk("R3 tx pop ignored", int'(tx_count), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule